// File: doc/BRIEF.md
# Directory Coherence Controller

This block keeps coherence for a set of processor caches that share one on-chip memory. For every memory block it stores a full presence vector, with one bit per cache, and a dirty flag that marks a block held modified by exactly one cache. Caches send it three kinds of request: a read miss, a request for write ownership, and an eviction. It answers each one with a single response that carries the block data from memory when permission is granted.

Suppose a cache asks to write a block that other caches hold. The controller sends one-cycle invalidation strobes only to the caches named in the presence vector. It counts their acknowledgements and sends the write grant only after the last one arrives. Suppose instead that a block is dirty in another cache. The controller first asks that owner to write the block back, stores the returned data in memory, and then serves the request. One request is in progress at a time. Each directory entry also carries a busy flag, so the block being worked on is locked until its response goes out.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every entry has no presence bits set and is clean, memory word i holds INIT_BASE + i, req_ready is high, and resp_valid, inv_valid and wb_valid are all low.
- R2: A read miss (req_op = 0) to a block not dirty elsewhere returns resp_kind 0 to the requester with the memory word. It sends no invalidation and no writeback request, and it adds the requester to the block's sharers.
- R3: A write request (req_op = 1) raises inv_valid bit c for one cycle, with inv_blk set to the block, exactly for each cache c whose presence bit is set, leaving out the requester.
- R4: The write grant (resp_kind 1) is issued only after every cache sent an invalidation has pulsed its inv_ack bit. An inv_ack pulse from a cache that was not sent an invalidation is ignored.
- R5: A write request to a block with no other sharers is granted without any invalidation.
- R6: After a write grant the block's presence vector holds only the writer and the block is dirty.
- R7: A read or write request to a block dirty in another cache first holds wb_valid with wb_dst set to the owner until wb_ack. It then writes wb_data to memory, clears the dirty flag and keeps the owner as a sharer. The request is served after that, so a read returns the written-back data.
- R8: A write request from the cache that already owns the dirty block is granted with no writeback request and no invalidation.
- R9: An eviction (req_op bit 1 set) answers with resp_kind 2. If the evicting cache is the dirty owner, req_data is written to memory and the dirty flag is cleared. A clean eviction leaves memory unchanged. In both cases only the evicting cache's presence bit is removed.
- R10: From the acceptance of a request until its response, req_ready stays low. A new request is accepted only in the idle state and only to a block that is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_op | input | 2 | 0 read miss, 1 write ownership, 2 or 3 eviction |
| req_src | input | $clog2(NCACHE) | Requesting cache |
| req_blk | input | $clog2(NBLK) | Block index |
| req_data | input | DW | Eviction data from a dirty owner |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_kind | output | 2 | 0 shared grant, 1 exclusive grant, 2 eviction done |
| resp_dst | output | $clog2(NCACHE) | Cache receiving the response |
| resp_blk | output | $clog2(NBLK) | Block of the response |
| resp_data | output | DW | Memory word for grants, zero for evictions |
| inv_valid | output | NCACHE | One-cycle invalidation strobe per cache |
| inv_blk | output | $clog2(NBLK) | Block being invalidated |
| inv_ack | input | NCACHE | One-cycle acknowledgement per cache |
| wb_valid | output | 1 | Writeback request, held until wb_ack |
| wb_dst | output | $clog2(NCACHE) | Owner asked to write back |
| wb_blk | output | $clog2(NBLK) | Block to write back |
| wb_ack | input | 1 | Owner returns data this cycle |
| wb_data | input | DW | Written-back block data |

## Verification
The hardest situation to reach is a write grant that is ready except for one straggling acknowledgement, while a stray acknowledgement from a cache that was never invalidated and a second request to another block both arrive during the wait. The bench builds this with two readers of a fresh block. Its cache stub holds back one reader's acknowledgement. A third cache then requests ownership, and the bench injects the stray pulse and queues the second request. It then checks that no grant appears and that req_ready stays low until the held acknowledgement is released. The ownership chain (shared, dirty, written back, shared by the old owner and the reader, then invalidated) comes from a vector table whose expected data follows each written-back value.

// File: rtl/dir_pkg.sv
// Shared encodings for the directory coherence controller.
// Assumes a two-bit request opcode and a two-bit response kind.
package dir_pkg;

    // Request opcodes; any opcode with bit 1 set is an eviction.
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2
    } op_e;

    // Response kinds returned to the requesting cache.
    typedef enum logic [1:0] {
        RK_SHARED = 2'd0,
        RK_EXCL   = 2'd1,
        RK_EVICT  = 2'd2
    } rk_e;

    // Transaction engine states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_DECIDE,
        S_WB,
        S_INV,
        S_MEMWAIT
    } st_e;

endpackage

// File: rtl/dir_table.sv
// Directory storage: one presence vector, one dirty flag and one busy flag
// per memory block. Assumes a single writer of entry state (the engine).
// Reads are combinational; writes take effect on the next edge.
module dir_table #(
    parameter int NCACHE = 4,
    parameter int NBLK   = 8,
    parameter int BW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BW-1:0]     rd_blk,
    output logic [NCACHE-1:0] rd_pres,
    output logic              rd_dirty,
    input  logic [BW-1:0]     rq_blk,
    output logic              rq_busy,
    input  logic              wr_en,
    input  logic [BW-1:0]     wr_blk,
    input  logic [NCACHE-1:0] wr_pres,
    input  logic              wr_dirty,
    input  logic              busy_set,
    input  logic [BW-1:0]     busy_set_blk,
    input  logic              busy_clr,
    input  logic [BW-1:0]     busy_clr_blk
);

    logic [NCACHE-1:0] pres  [NBLK];
    logic              dirty [NBLK];
    logic              busy  [NBLK];

    // Entry state update: reset clears all, else apply write and busy changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) begin
                pres[i]  <= '0;
                dirty[i] <= 1'b0;
                busy[i]  <= 1'b0;
            end
        end else begin
            if (wr_en) begin
                pres[wr_blk]  <= wr_pres;
                dirty[wr_blk] <= wr_dirty;
            end
            if (busy_set) busy[busy_set_blk] <= 1'b1;
            if (busy_clr) busy[busy_clr_blk] <= 1'b0;
        end
    end

    // Combinational read ports for the engine and the request gate.
    always_comb begin
        rd_pres  = pres[rd_blk];
        rd_dirty = dirty[rd_blk];
        rq_busy  = busy[rq_blk];
    end

endmodule

// File: rtl/dir_mem.sv
// Behavioural backing memory with a fixed read latency of LAT cycles.
// Word i resets to INIT_BASE + i. Writes land on the next edge; the engine
// never reads and writes in the same cycle. Assumes LAT >= 1.
module dir_mem #(
    parameter int NBLK      = 8,
    parameter int DW        = 8,
    parameter int BW        = 3,
    parameter int LAT       = 2,
    parameter int INIT_BASE = 160
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_go,
    input  logic [BW-1:0] raddr,
    output logic          rd_done,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [NBLK];
    logic          stg_vld [LAT];
    logic [DW-1:0] stg_dat [LAT];

    // Array write port, with the reset pattern loaded on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) mem[i] <= DW'(INIT_BASE + i);
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // First latency stage: capture the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld[0] <= 1'b0;
            stg_dat[0] <= '0;
        end else begin
            stg_vld[0] <= rd_go;
            stg_dat[0] <= mem[raddr];
        end
    end

    // Remaining latency stages, one register per extra cycle.
    for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_vld[s] <= 1'b0;
                stg_dat[s] <= '0;
            end else begin
                stg_vld[s] <= stg_vld[s-1];
                stg_dat[s] <= stg_dat[s-1];
            end
        end
    end

    assign rd_done = stg_vld[LAT-1];
    assign rd_data = stg_dat[LAT-1];

endmodule

// File: rtl/dir_inv_track.sv
// Acknowledgement tracker for one invalidation round. On load it records
// the caches that were sent an invalidation and counts them. Each later ack
// from a recorded cache decrements the count once. Acks from other caches
// are dropped. done is high when nothing is outstanding.
module dir_inv_track #(
    parameter int NCACHE = 4,
    parameter int NW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NCACHE-1:0] targets,
    input  logic [NCACHE-1:0] ack,
    output logic [NW-1:0]     cnt,
    output logic              done
);

    logic [NCACHE-1:0] pend;
    logic [NCACHE-1:0] hits;

    // Population count of a cache mask.
    function automatic logic [NW-1:0] popc(input logic [NCACHE-1:0] v);
        logic [NW-1:0] r;
        r = '0;
        for (int i = 0; i < NCACHE; i++) r = r + NW'(v[i]);
        return r;
    endfunction

    assign hits = ack & pend;

    // Load a new round or retire acknowledged caches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
            cnt  <= '0;
        end else if (load) begin
            pend <= targets;
            cnt  <= popc(targets);
        end else begin
            pend <= pend & ~hits;
            cnt  <= cnt - popc(hits);
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/dir_ctrl.sv
// Full-map directory coherence controller (top). Serves one request at a
// time: read miss, write ownership or eviction. It recalls a dirty line
// from its owner before serving another cache. It invalidates only the
// recorded sharers and grants ownership once all of them have acknowledged.
// Assumes caches acknowledge each invalidation exactly once and an owner
// answers a writeback request exactly once.
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NCACHE    = 4,
    parameter int NBLK      = 8,
    parameter int DW        = 8,
    parameter int MEM_LAT   = 2,
    parameter int INIT_BASE = 160
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [1:0]                            req_op,
    input  logic [((NCACHE>1)?$clog2(NCACHE):1)-1:0] req_src,
    input  logic [((NBLK>1)?$clog2(NBLK):1)-1:0]  req_blk,
    input  logic [DW-1:0]                         req_data,
    output logic                                  resp_valid,
    output logic [1:0]                            resp_kind,
    output logic [((NCACHE>1)?$clog2(NCACHE):1)-1:0] resp_dst,
    output logic [((NBLK>1)?$clog2(NBLK):1)-1:0]  resp_blk,
    output logic [DW-1:0]                         resp_data,
    output logic [NCACHE-1:0]                     inv_valid,
    output logic [((NBLK>1)?$clog2(NBLK):1)-1:0]  inv_blk,
    input  logic [NCACHE-1:0]                     inv_ack,
    output logic                                  wb_valid,
    output logic [((NCACHE>1)?$clog2(NCACHE):1)-1:0] wb_dst,
    output logic [((NBLK>1)?$clog2(NBLK):1)-1:0]  wb_blk,
    input  logic                                  wb_ack,
    input  logic [DW-1:0]                         wb_data
);

    localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1;
    localparam int BW = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam int NW = $clog2(NCACHE + 1);

    st_e               state, nxt;
    logic [1:0]        op_q;
    logic [CW-1:0]     src_q;
    logic [BW-1:0]     blk_q;
    logic [DW-1:0]     data_q;

    logic [NCACHE-1:0] tbl_pres;
    logic              tbl_dirty;
    logic              rq_busy;
    logic              tbl_we;
    logic [NCACHE-1:0] wr_pres;
    logic              wr_dirty;
    logic              bset, bclr;

    logic              mem_we;
    logic [DW-1:0]     mem_wdata;
    logic              rd_go, rd_done;
    logic [DW-1:0]     rd_data;

    logic              inv_load;
    logic [NW-1:0]     trk_cnt;
    logic              trk_done;

    logic [NCACHE-1:0] src_oh;
    logic [NCACHE-1:0] targets;
    logic [CW-1:0]     owner;
    logic              own_other, own_self;
    logic              resp_set;
    logic [1:0]        kind_n;
    logic [NCACHE-1:0] inv_q;

    // Index of the lowest set bit; the owner when the entry is dirty.
    function automatic logic [CW-1:0] first_set(input logic [NCACHE-1:0] v);
        logic [CW-1:0] r;
        r = '0;
        for (int i = NCACHE - 1; i >= 0; i--) if (v[i]) r = CW'(i);
        return r;
    endfunction

    dir_table #(.NCACHE(NCACHE), .NBLK(NBLK), .BW(BW)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_blk       (blk_q),
        .rd_pres      (tbl_pres),
        .rd_dirty     (tbl_dirty),
        .rq_blk       (req_blk),
        .rq_busy      (rq_busy),
        .wr_en        (tbl_we),
        .wr_blk       (blk_q),
        .wr_pres      (wr_pres),
        .wr_dirty     (wr_dirty),
        .busy_set     (bset),
        .busy_set_blk (req_blk),
        .busy_clr     (bclr),
        .busy_clr_blk (blk_q)
    );

    dir_mem #(.NBLK(NBLK), .DW(DW), .BW(BW), .LAT(MEM_LAT),
              .INIT_BASE(INIT_BASE)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (blk_q),
        .wdata   (mem_wdata),
        .rd_go   (rd_go),
        .raddr   (blk_q),
        .rd_done (rd_done),
        .rd_data (rd_data)
    );

    dir_inv_track #(.NCACHE(NCACHE), .NW(NW)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (inv_load),
        .targets (targets),
        .ack     (inv_ack),
        .cnt     (trk_cnt),
        .done    (trk_done)
    );

    // Entry-derived decode for the block under service.
    always_comb begin
        src_oh    = NCACHE'(1) << src_q;
        targets   = tbl_pres & ~src_oh;
        owner     = first_set(tbl_pres);
        own_other = tbl_dirty && (owner != src_q);
        own_self  = tbl_dirty && (owner == src_q);
    end

    assign req_ready = (state == S_IDLE) && !rq_busy;

    // Next-state and per-cycle control strobes of the engine.
    always_comb begin
        nxt       = state;
        tbl_we    = 1'b0;
        wr_pres   = tbl_pres;
        wr_dirty  = tbl_dirty;
        bset      = 1'b0;
        bclr      = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = data_q;
        rd_go     = 1'b0;
        inv_load  = 1'b0;
        resp_set  = 1'b0;
        kind_n    = RK_SHARED;
        unique case (state)
            S_IDLE: begin
                if (req_valid && req_ready) begin
                    bset = 1'b1;
                    nxt  = S_DECIDE;
                end
            end
            S_DECIDE: begin
                if (op_q[1]) begin
                    mem_we   = own_self;
                    tbl_we   = 1'b1;
                    wr_pres  = tbl_pres & ~src_oh;
                    wr_dirty = own_other;
                    bclr     = 1'b1;
                    resp_set = 1'b1;
                    kind_n   = RK_EVICT;
                    nxt      = S_IDLE;
                end else if (own_other) begin
                    nxt = S_WB;
                end else if (op_q == OP_WRITE) begin
                    inv_load = 1'b1;
                    if (targets == '0) begin
                        rd_go = 1'b1;
                        nxt   = S_MEMWAIT;
                    end else begin
                        nxt = S_INV;
                    end
                end else begin
                    rd_go = 1'b1;
                    nxt   = S_MEMWAIT;
                end
            end
            S_WB: begin
                if (wb_ack) begin
                    mem_we    = 1'b1;
                    mem_wdata = wb_data;
                    tbl_we    = 1'b1;
                    wr_dirty  = 1'b0;
                    nxt       = S_DECIDE;
                end
            end
            S_INV: begin
                if (trk_done) begin
                    rd_go = 1'b1;
                    nxt   = S_MEMWAIT;
                end
            end
            S_MEMWAIT: begin
                if (rd_done) begin
                    tbl_we   = 1'b1;
                    bclr     = 1'b1;
                    resp_set = 1'b1;
                    if (op_q == OP_WRITE) begin
                        wr_pres  = src_oh;
                        wr_dirty = 1'b1;
                        kind_n   = RK_EXCL;
                    end else begin
                        wr_pres  = tbl_pres | src_oh;
                        wr_dirty = 1'b0;
                        kind_n   = RK_SHARED;
                    end
                    nxt = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State, request capture and registered response/invalidation outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= '0;
            src_q      <= '0;
            blk_q      <= '0;
            data_q     <= '0;
            resp_valid <= 1'b0;
            resp_kind  <= '0;
            resp_dst   <= '0;
            resp_blk   <= '0;
            resp_data  <= '0;
            inv_q      <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && req_valid && req_ready) begin
                op_q   <= req_op;
                src_q  <= req_src;
                blk_q  <= req_blk;
                data_q <= req_data;
            end
            resp_valid <= resp_set;
            if (resp_set) begin
                resp_kind <= kind_n;
                resp_dst  <= src_q;
                resp_blk  <= blk_q;
                resp_data <= (state == S_DECIDE) ? '0 : rd_data;
            end
            inv_q <= inv_load ? targets : '0;
        end
    end

    assign inv_valid = inv_q;
    assign inv_blk   = blk_q;
    assign wb_valid  = (state == S_WB);
    assign wb_dst    = owner;
    assign wb_blk    = blk_q;

endmodule

// File: rtl/dir_ctrl_chk.sv
// Protocol checker for dir_ctrl, attached by bind. It observes ports and
// the boundaries between the engine, the directory table and the ack tracker.
module dir_ctrl_chk #(
    parameter int NCACHE = 4,
    parameter int CW     = 2,
    parameter int NW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_kind,
    input logic [NCACHE-1:0] inv_valid,
    input logic              wb_valid,
    input logic              wb_ack,
    input logic [CW-1:0]     wb_dst,
    input logic [CW-1:0]     src_q,
    input logic [NCACHE-1:0] tbl_pres,
    input logic              tbl_dirty,
    input logic [NW-1:0]     trk_cnt
);

    // R4
    excl_after_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'd1) |-> (trk_cnt == '0));

    // R3
    inv_skips_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |-> !inv_valid[src_q]);

    // R3
    inv_only_sharers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inv_valid) |-> ((inv_valid & ~$past(tbl_pres)) == '0));

    // R10
    one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    wb_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_dst)));

    // R6
    dirty_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_dirty |-> ($countones(tbl_pres) == 1));

endmodule

bind dir_ctrl dir_ctrl_chk #(.NCACHE(NCACHE), .CW(CW), .NW(NW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_kind  (resp_kind),
    .inv_valid  (inv_valid),
    .wb_valid   (wb_valid),
    .wb_ack     (wb_ack),
    .wb_dst     (wb_dst),
    .src_q      (src_q),
    .tbl_pres   (tbl_pres),
    .tbl_dirty  (tbl_dirty),
    .trk_cnt    (trk_cnt)
);

// File: tb/dir_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for dir_ctrl: a vector table walked by one loop, then directed
// tests. Behavioural cache stubs answer invalidations and writeback requests.
module dir_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = '0;
    logic [1:0] req_src = '0;
    logic [2:0] req_blk = '0;
    logic [7:0] req_data = '0;
    logic       resp_valid;
    logic [1:0] resp_kind;
    logic [1:0] resp_dst;
    logic [2:0] resp_blk;
    logic [7:0] resp_data;
    logic [3:0] inv_valid;
    logic [2:0] inv_blk;
    logic [3:0] inv_ack;
    logic       wb_valid;
    logic [1:0] wb_dst;
    logic [2:0] wb_blk;
    logic       wb_ack_r = 1'b0;
    logic [7:0] wb_data_r = '0;

    // Stub state.
    logic [3:0] stub_ack = '0;
    logic [3:0] stub_pend = '0;
    logic [2:0] stub_cnt [4];
    logic [3:0] hold = '0;
    logic [3:0] spur_ack = '0;
    logic [7:0] stub_data [4][8];
    logic [1:0] wb_wait = '0;
    logic       wb_srv = 1'b0;

    int nchk = 0;
    int nfail = 0;

    // Observation accumulators for the transaction in progress.
    logic       got;
    logic [1:0] got_kind;
    logic [7:0] got_data;
    logic [1:0] got_dst;
    logic [3:0] inv_seen;
    logic [2:0] wb_seen;
    logic       early;

    always #4 clk = ~clk;

    assign inv_ack = stub_ack | spur_ack;

    dir_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_dst(resp_dst),
        .resp_blk(resp_blk), .resp_data(resp_data),
        .inv_valid(inv_valid), .inv_blk(inv_blk), .inv_ack(inv_ack),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_blk(wb_blk),
        .wb_ack(wb_ack_r), .wb_data(wb_data_r)
    );

    // Invalidation stub: cache c acks c+1 negedges after its strobe unless held.
    always @(negedge clk) begin
        for (int c = 0; c < 4; c++) begin
            if (inv_valid[c]) begin
                stub_pend[c] <= 1'b1;
                stub_cnt[c]  <= 3'(c);
                stub_ack[c]  <= 1'b0;
            end else if (stub_pend[c] && !hold[c]) begin
                if (stub_cnt[c] == 3'd0) begin
                    stub_ack[c]  <= 1'b1;
                    stub_pend[c] <= 1'b0;
                end else begin
                    stub_cnt[c] <= stub_cnt[c] - 3'd1;
                end
            end else begin
                stub_ack[c] <= 1'b0;
            end
        end
    end

    // Writeback stub: the owner returns its copy three negedges after the request.
    always @(negedge clk) begin
        if (wb_valid && !wb_srv) begin
            if (wb_wait == 2'd2) begin
                wb_ack_r  <= 1'b1;
                wb_data_r <= stub_data[wb_dst][wb_blk];
                wb_srv    <= 1'b1;
                wb_wait   <= '0;
            end else begin
                wb_wait <= wb_wait + 2'd1;
            end
        end else begin
            wb_ack_r <= 1'b0;
            if (!wb_valid) wb_srv <= 1'b0;
        end
    end

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] src;
        logic [2:0] blk;
        logic [7:0] wdat;
        logic [1:0] kind;
        logic [7:0] rdat;
        logic [3:0] inv;
        logic [2:0] wb;
    } vec_t;

    // op, src, blk, data, expected kind, expected data, invalidation mask,
    // writeback owner + 1 (0 = none). Memory word i starts at 0xA0 + i.
    localparam vec_t VEC [18] = '{
        '{2'd0, 2'd0, 3'd1, 8'h00, 2'd0, 8'hA1, 4'h0, 3'd0},
        '{2'd0, 2'd1, 3'd1, 8'h00, 2'd0, 8'hA1, 4'h0, 3'd0},
        '{2'd0, 2'd2, 3'd1, 8'h00, 2'd0, 8'hA1, 4'h0, 3'd0},
        '{2'd1, 2'd3, 3'd1, 8'h55, 2'd1, 8'hA1, 4'h7, 3'd0},
        '{2'd0, 2'd0, 3'd1, 8'h00, 2'd0, 8'h55, 4'h0, 3'd4},
        '{2'd1, 2'd0, 3'd1, 8'h66, 2'd1, 8'h55, 4'h8, 3'd0},
        '{2'd1, 2'd0, 3'd1, 8'h77, 2'd1, 8'h55, 4'h0, 3'd0},
        '{2'd1, 2'd2, 3'd1, 8'h88, 2'd1, 8'h77, 4'h1, 3'd1},
        '{2'd2, 2'd2, 3'd1, 8'h88, 2'd2, 8'h00, 4'h0, 3'd0},
        '{2'd0, 2'd1, 3'd1, 8'h00, 2'd0, 8'h88, 4'h0, 3'd0},
        '{2'd1, 2'd1, 3'd2, 8'h99, 2'd1, 8'hA2, 4'h0, 3'd0},
        '{2'd2, 2'd1, 3'd1, 8'h00, 2'd2, 8'h00, 4'h0, 3'd0},
        '{2'd0, 2'd0, 3'd1, 8'h00, 2'd0, 8'h88, 4'h0, 3'd0},
        '{2'd1, 2'd2, 3'd1, 8'h11, 2'd1, 8'h88, 4'h1, 3'd0},
        '{2'd0, 2'd2, 3'd2, 8'h00, 2'd0, 8'h99, 4'h0, 3'd2},
        '{2'd2, 2'd1, 3'd2, 8'hEE, 2'd2, 8'h00, 4'h0, 3'd0},
        '{2'd0, 2'd3, 3'd2, 8'h00, 2'd0, 8'h99, 4'h0, 3'd0},
        '{2'd1, 2'd3, 3'd2, 8'h12, 2'd1, 8'h99, 4'h4, 3'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One observation step, sampled at the falling edge.
    task automatic tick();
        @(negedge clk);
        inv_seen = inv_seen | inv_valid;
        if (wb_valid) wb_seen = 3'(wb_dst) + 3'd1;
        if (resp_valid) begin
            got      = 1'b1;
            got_kind = resp_kind;
            got_data = resp_data;
            got_dst  = resp_dst;
            if (resp_kind == 2'd1 && (|stub_pend)) early = 1'b1;
        end
    endtask

    task automatic clear_obs();
        got = 1'b0; got_kind = '0; got_data = '0; got_dst = '0;
        inv_seen = '0; wb_seen = '0; early = 1'b0;
    endtask

    // Present a request and return once it has been accepted.
    task automatic issue(input logic [1:0] op, input logic [1:0] src,
                         input logic [2:0] blk, input logic [7:0] d);
        clear_obs();
        req_op = op; req_src = src; req_blk = blk; req_data = d;
        req_valid = 1'b1;
        while (!req_ready) tick();
        tick();
        req_valid = 1'b0;
    endtask

    task automatic wait_resp(input int limit);
        for (int i = 0; i < limit && !got; i++) tick();
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin
            stub_cnt[c] = '0;
            for (int b = 0; b < 8; b++) stub_data[c][b] = '0;
        end
        clear_obs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle outputs after reset.
        check("R1 req_ready", int'(req_ready), 1);
        check("R1 resp_valid", int'(resp_valid), 0);
        check("R1 inv_valid", int'(inv_valid), 0);
        check("R1 wb_valid", int'(wb_valid), 0);

        // Table walk: R1 R2 R3 R5 R6 R7 R8 R9 across the ownership chain.
        for (int v = 0; v < 18; v++) begin
            string tg;
            if (VEC[v].op[1])            tg = "R9";
            else if (VEC[v].wb != 3'd0)  tg = "R7";
            else if (VEC[v].op == 2'd1)  tg = (VEC[v].inv == 4'h0) ? "R8/R5" : "R3/R6";
            else                         tg = (v == 0) ? "R1/R2" : "R2";
            issue(VEC[v].op, VEC[v].src, VEC[v].blk, VEC[v].wdat);
            wait_resp(200);
            check({tg, " response seen"}, int'(got), 1);
            check({tg, " kind"}, int'(got_kind), int'(VEC[v].kind));
            check({tg, " data"}, int'(got_data), int'(VEC[v].rdat));
            check({tg, " dst"}, int'(got_dst), int'(VEC[v].src));
            check({tg, " invalidation mask"}, int'(inv_seen), int'(VEC[v].inv));
            check({tg, " writeback owner"}, int'(wb_seen), int'(VEC[v].wb));
            check("R4 grant before acks", int'(early), 0);
            if (got && got_kind == 2'd1) stub_data[VEC[v].src][VEC[v].blk] = VEC[v].wdat;
        end

        // Directed R4/R10: two sharers of block 3, one ack held back.
        issue(2'd0, 2'd0, 3'd3, 8'h00);
        wait_resp(200);
        check("R2 read block3 c0", int'(got_data), 'hA3);
        issue(2'd0, 2'd1, 3'd3, 8'h00);
        wait_resp(200);
        check("R2 read block3 c1", int'(got_data), 'hA3);
        hold = 4'b0010;
        issue(2'd1, 2'd2, 3'd3, 8'h5A);
        // Queue a read of block 4 by cache 3 and inject a stray ack from cache 3.
        req_op = 2'd0; req_src = 2'd3; req_blk = 3'd4; req_data = '0;
        req_valid = 1'b1;
        begin
            logic rdy_seen;
            rdy_seen = 1'b0;
            for (int i = 0; i < 30; i++) begin
                spur_ack = (i == 10) ? 4'b1000 : 4'b0000;
                tick();
                if (req_ready) rdy_seen = 1'b1;
            end
            spur_ack = '0;
            check("R4 no grant with held ack and stray ack", int'(got), 0);
            check("R10 req_ready low while busy", int'(rdy_seen), 0);
        end
        check("R3 invalidated sharers only", int'(inv_seen), 'h3);
        hold = '0;
        wait_resp(200);
        check("R4 grant after last ack", int'(got), 1);
        check("R4 grant kind", int'(got_kind), 1);
        check("R4 grant data", int'(got_data), 'hA3);
        check("R4 early grant", int'(early), 0);
        // The queued request is accepted on the next edge.
        tick();
        req_valid = 1'b0;
        clear_obs();
        wait_resp(200);
        check("R10 queued request served", int'(got), 1);
        check("R10 queued request data", int'(got_data), 'hA4);
        check("R10 queued request dst", int'(got_dst), 3);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
        $finish;
    end

endmodule